// File: doc/BRIEF.md
# CCD Timing Strobe Mapper

This block sits behind the timing pins of a CCD analog front end. It takes six externally generated timing levels: the converter clock, the reset-phase pixel clock, the clamp pulse, the calibration pulse, the sample-pixel marker and the sample-blank marker. It passes each one through a two-flop synchronizer. It then normalizes each one to active-high using a per-input polarity bit. From these normalized levels it derives the internal control strobes: the DC-restore bias enable, the optical-black pixel flag, the vertical-shift reject window and the reset-reject switch drive.

A set of static mode inputs decides which input plays which role. One mode bit hands DC restore to the calibration pulse and moves the clamp pulse over to vertical-shift reject qualification. Another bit records whether clamp or calibration comes last on a line. A third bit keeps the bias on at all times.

The second-phase start strobe is a one-cycle pulse. It is timed in fast-clock ticks from one of two edge sources. The first source is the end of the blanking marker, delayed by the sum of two 3-bit codes. The second source is the start of the pixel marker, delayed by a single 3-bit code. A new edge that arrives while a countdown is still running restarts the countdown.

Top module: `ccd_strobe_map`

## Requirements
- R1: Bit order of `raw_in`, `pol_cfg` and `sig_norm` is 0 converter clock, 1 pixel clock, 2 clamp, 3 calibration, 4 pixel marker, 5 blank marker. A raw level sampled at clock edge k appears on `sig_norm` after edge k+1. The bit equals the raw level when its polarity bit is 1 and the inverted raw level when it is 0.
- R2: While `bias_always` is 1, `bias_en` is 1.
- R3: While `bias_always` is 0, `bias_en` follows normalized clamp when `cal_only` is 0 and normalized calibration when `cal_only` is 1.
- R4: `ob_flag` follows normalized calibration in both settings of `cal_only`.
- R5: With `vsr_en` at 1, `vsr_win` follows a qualifier chosen as follows:
  - normalized clamp when `cal_only` is 1;
  - otherwise the pulse that ends the line: calibration when `cal_first` is 0, clamp when `cal_first` is 1.
- R6: While `vsr_en` is 0, `vsr_win` stays 0.
- R7: `rr_sw` is 1 while `rr_clocked` is 0, and follows the normalized pixel clock while `rr_clocked` is 1.
- R8: With `spix_ref` at 0, the trigger is a normalized blank-marker fall whose raw change is sampled at edge k. `p2_start` is then high for exactly the one cycle after edge k+2+D, where D = `dly_p1_trail` + `dly_spix` (0 to 14). Pixel-marker edges start nothing in this mode.
- R9: With `spix_ref` at 1, the trigger is a normalized pixel-marker rise whose raw change is sampled at edge k. `p2_start` is then high for exactly the one cycle after edge k+2+D, where D = `dly_p2_lead` (0 to 7).
- R10: A trigger arriving while a countdown is pending discards the pending pulse and times a single pulse from the new trigger.
- R11: While `rst` is high, `sig_norm`, `ob_flag`, `vsr_win` and `p2_start` are 0 whatever the raw inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast oversampling clock |
| rst | input | 1 | synchronous active-high reset |
| raw_in | input | 6 | raw timing inputs, order as in R1 |
| pol_cfg | input | 6 | polarity per input, 1 = active high |
| bias_always | input | 1 | keep DC-restore bias on |
| cal_only | input | 1 | calibration drives DC restore; clamp qualifies reject |
| cal_first | input | 1 | calibration at line start, clamp at line end |
| spix_ref | input | 1 | time second phase from the pixel-marker rise |
| rr_clocked | input | 1 | clock the reset-reject switch |
| vsr_en | input | 1 | enable vertical-shift reject |
| dly_p1_trail | input | 3 | first-phase trailing delay code, in ticks |
| dly_spix | input | 3 | marker-option delay code, in ticks |
| dly_p2_lead | input | 3 | second-phase leading delay code, in ticks |
| sig_norm | output | 6 | synchronized, normalized input levels |
| bias_en | output | 1 | DC-restore bias enable |
| ob_flag | output | 1 | optical-black pixel flag |
| vsr_win | output | 1 | vertical-shift reject window |
| rr_sw | output | 1 | reset-reject switch drive |
| p2_start | output | 1 | one-cycle second-phase start strobe |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:
- Both delay extremes (sum 0 and sum 14, single code 0). A design that drops a carry in the summed code, or adds a tick at zero delay, lands the pulse in the wrong cycle.
- A retrigger inside a long countdown. A design that does not restart emits two pulses or an early one.
- A pixel-marker edge while blank-marker timing is selected. A design with a loose source mux fires a stray pulse.
- Random polarity and mode mixes across the role mapping. These catch a swapped clamp/calibration role or an inverted polarity sense as a wrong strobe level.

// File: rtl/ccd_map_pkg.sv
package ccd_map_pkg;
    localparam int NSIG      = 6;
    localparam int IDX_ADC   = 0;
    localparam int IDX_PIX   = 1;
    localparam int IDX_CLAMP = 2;
    localparam int IDX_CAL   = 3;
    localparam int IDX_SPIX  = 4;
    localparam int IDX_SBLK  = 5;

    typedef struct packed {
        logic bias_always;
        logic cal_only;
        logic cal_first;
        logic rr_clocked;
        logic vsr_en;
    } role_mode_t;

    typedef struct packed {
        logic bias_en;
        logic ob_flag;
        logic vsr_win;
        logic rr_sw;
    } strobes_t;

    // widen two codes by one bit and add them
    function automatic logic [3:0] sum_codes(input logic [2:0] a, input logic [2:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction
endpackage

// File: rtl/ccd_in_sync.sv
module ccd_in_sync #(
    parameter int N        = 6,
    parameter int RISE_IDX = 4,
    parameter int FALL_IDX = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    output logic [N-1:0] lvl,
    output logic         rise_ev,
    output logic         fall_ev
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic         rise_prev;
    logic         fall_prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // reset to the inactive raw level so no edge appears out of reset
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= ~pol[i];
                sync_q[i] <= ~pol[i];
            end else begin
                meta_q[i] <= raw[i];
                sync_q[i] <= meta_q[i];
            end
        end
        assign lvl[i] = sync_q[i] ^ ~pol[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_prev <= 1'b0;
            fall_prev <= 1'b0;
        end else begin
            rise_prev <= lvl[RISE_IDX];
            fall_prev <= lvl[FALL_IDX];
        end
    end

    assign rise_ev = lvl[RISE_IDX] & ~rise_prev;
    assign fall_ev = ~lvl[FALL_IDX] & fall_prev;
endmodule

// File: rtl/ccd_role_mux.sv
module ccd_role_mux
    import ccd_map_pkg::*;
(
    input  role_mode_t mode,
    input  logic       clamp_a,
    input  logic       cal_a,
    input  logic       pix_a,
    output strobes_t   strb
);
    logic restore_src;
    logic reject_qual;

    always_comb begin
        restore_src = mode.cal_only ? cal_a : clamp_a;
        // clamp is the qualifier once calibration owns restore;
        // otherwise the pulse that closes the line frames the window
        if (mode.cal_only)
            reject_qual = clamp_a;
        else
            reject_qual = mode.cal_first ? clamp_a : cal_a;

        strb.bias_en = mode.bias_always | restore_src;
        strb.ob_flag = cal_a;
        strb.vsr_win = mode.vsr_en & reject_qual;
        strb.rr_sw   = mode.rr_clocked ? pix_a : 1'b1;
    end
endmodule

// File: rtl/ccd_delay_pulse.sv
module ccd_delay_pulse #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [CW-1:0] dly,
    output logic          pulse
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (trig) begin
                // a fresh trigger always wins over a pending count
                if (dly == '0) begin
                    pulse_q <= 1'b1;
                    busy_q  <= 1'b0;
                end else begin
                    cnt_q  <= dly;
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    pulse_q <= 1'b1;
                    busy_q  <= 1'b0;
                end
            end
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/ccd_strobe_map.sv
module ccd_strobe_map
    import ccd_map_pkg::*;
#(
    parameter int CODE_W = 3,
    localparam int SUM_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSIG-1:0]   raw_in,
    input  logic [NSIG-1:0]   pol_cfg,
    input  logic              bias_always,
    input  logic              cal_only,
    input  logic              cal_first,
    input  logic              spix_ref,
    input  logic              rr_clocked,
    input  logic              vsr_en,
    input  logic [CODE_W-1:0] dly_p1_trail,
    input  logic [CODE_W-1:0] dly_spix,
    input  logic [CODE_W-1:0] dly_p2_lead,
    output logic [NSIG-1:0]   sig_norm,
    output logic              bias_en,
    output logic              ob_flag,
    output logic              vsr_win,
    output logic              rr_sw,
    output logic              p2_start
);
    logic [NSIG-1:0] lvl;
    logic            spix_rise;
    logic            sblk_fall;
    role_mode_t      mode;
    strobes_t        strb;
    logic            p2_trig;
    logic [SUM_W-1:0] p2_dly;

    ccd_in_sync #(
        .N       (NSIG),
        .RISE_IDX(IDX_SPIX),
        .FALL_IDX(IDX_SBLK)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_in),
        .pol    (pol_cfg),
        .lvl    (lvl),
        .rise_ev(spix_rise),
        .fall_ev(sblk_fall)
    );

    assign mode = '{bias_always: bias_always, cal_only: cal_only,
                    cal_first: cal_first, rr_clocked: rr_clocked,
                    vsr_en: vsr_en};

    ccd_role_mux u_roles (
        .mode   (mode),
        .clamp_a(lvl[IDX_CLAMP]),
        .cal_a  (lvl[IDX_CAL]),
        .pix_a  (lvl[IDX_PIX]),
        .strb   (strb)
    );

    // trigger source and delay chain are chosen together
    always_comb begin
        if (spix_ref) begin
            p2_trig = spix_rise;
            p2_dly  = {1'b0, dly_p2_lead};
        end else begin
            p2_trig = sblk_fall;
            p2_dly  = sum_codes(dly_p1_trail, dly_spix);
        end
    end

    ccd_delay_pulse #(.CW(SUM_W)) u_p2 (
        .clk  (clk),
        .rst  (rst),
        .trig (p2_trig),
        .dly  (p2_dly),
        .pulse(p2_start)
    );

    assign sig_norm = lvl;
    assign bias_en  = strb.bias_en;
    assign ob_flag  = strb.ob_flag;
    assign vsr_win  = strb.vsr_win;
    assign rr_sw    = strb.rr_sw;
endmodule

// File: rtl/ccd_strobe_map_chk.sv
module ccd_strobe_map_chk (
    input logic clk,
    input logic rst,
    input logic bias_always,
    input logic cal_only,
    input logic cal_first,
    input logic spix_ref,
    input logic rr_clocked,
    input logic vsr_en,
    input logic norm_pix,
    input logic norm_clamp,
    input logic norm_cal,
    input logic bias_en,
    input logic ob_flag,
    input logic vsr_win,
    input logic rr_sw,
    input logic p2_start
);
    // R2
    bias_forced_chk: assert property (@(posedge clk) disable iff (rst)
        bias_always |-> bias_en);

    // R3
    bias_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (!bias_always && !cal_only) |-> (bias_en == norm_clamp));

    // R3
    bias_cal_chk: assert property (@(posedge clk) disable iff (rst)
        (!bias_always && cal_only) |-> (bias_en == norm_cal));

    // R4
    ob_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ob_flag == norm_cal);

    // R5
    vsr_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (vsr_en && (cal_only || cal_first)) |-> (vsr_win == norm_clamp));

    // R6
    vsr_off_chk: assert property (@(posedge clk) disable iff (rst)
        !vsr_en |-> !vsr_win);

    // R7
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rr_clocked |-> rr_sw);

    // R7
    rr_clock_chk: assert property (@(posedge clk) disable iff (rst)
        rr_clocked |-> (rr_sw == norm_pix));

    // R8 R9
    p2_single_chk: assert property (@(posedge clk) disable iff (rst)
        (p2_start && $stable(spix_ref)) |=> !p2_start);
endmodule

bind ccd_strobe_map ccd_strobe_map_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bias_always(bias_always),
    .cal_only   (cal_only),
    .cal_first  (cal_first),
    .spix_ref   (spix_ref),
    .rr_clocked (rr_clocked),
    .vsr_en     (vsr_en),
    .norm_pix   (sig_norm[1]),
    .norm_clamp (sig_norm[2]),
    .norm_cal   (sig_norm[3]),
    .bias_en    (bias_en),
    .ob_flag    (ob_flag),
    .vsr_win    (vsr_win),
    .rr_sw      (rr_sw),
    .p2_start   (p2_start)
);

// File: tb/ccd_strobe_map_test.sv
`timescale 1ns/1ps
module ccd_strobe_map_test;
    localparam int PIX = 1, CLAMP = 2, CAL = 3, SPIX = 4, SBLK = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] raw_in = '0, pol_cfg = '0, sig_norm;
    logic       bias_always = 0, cal_only = 0, cal_first = 0, spix_ref = 0;
    logic       rr_clocked = 0, vsr_en = 0;
    logic [2:0] dly_p1_trail = 0, dly_spix = 0, dly_p2_lead = 0;
    logic       bias_en, ob_flag, vsr_win, rr_sw, p2_start;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ccd_strobe_map uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic drive(input int idx, input bit active);
        raw_in[idx] = active ? pol_cfg[idx] : ~pol_cfg[idx];
    endtask

    function automatic logic [3:0] exp_roles(input logic [5:0] n);
        logic b, o, v, r, q;
        b = bias_always | (cal_only ? n[CAL] : n[CLAMP]);
        o = n[CAL];
        q = cal_only ? n[CLAMP] : (cal_first ? n[CLAMP] : n[CAL]);
        v = vsr_en & q;
        r = rr_clocked ? n[PIX] : 1'b1;
        return {b, o, v, r};
    endfunction

    // counts posedges from now; expects one pulse in cycle exp_c (or none if exp_c<0)
    task automatic pulse_window(input string req, input int exp_c, input int win);
        int first = -1;
        int hits = 0;
        for (int c = 1; c <= win; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (p2_start) begin
                hits++;
                if (first < 0) first = c;
            end
        end
        check(first == exp_c && hits == (exp_c < 0 ? 0 : 1), req, first, exp_c);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        pol_cfg = 6'b101010;
        raw_in  = 6'b111111;
        cycles(3);
        // R11 reset holds outputs low
        check(sig_norm == 6'b0, "R11 sig_norm", sig_norm, 0);
        check(p2_start == 1'b0 && ob_flag == 1'b0 && vsr_win == 1'b0, "R11 strobes",
              {p2_start, ob_flag, vsr_win}, 0);
        rst = 1'b0;
        cycles(3);
        // R1 normalization: raw all ones, pol 101010
        check(sig_norm == 6'b101010, "R1 levels", sig_norm, 6'b101010);

        // R1 latency: change sampled at edge 1 visible after edge 2
        raw_in[0] = 1'b0;           // pol 0 -> active
        @(posedge clk); @(negedge clk);
        check(sig_norm[0] == 1'b0, "R1 not yet", sig_norm[0], 0);
        @(posedge clk); @(negedge clk);
        check(sig_norm[0] == 1'b1, "R1 latency", sig_norm[0], 1);

        // random role mapping R2..R7
        for (int it = 0; it < 40; it++) begin
            logic [3:0] e;
            pol_cfg = 6'($urandom);
            raw_in  = 6'($urandom);
            {bias_always, cal_only, cal_first, rr_clocked, vsr_en} = 5'($urandom);
            spix_ref = 1'b1;
            cycles(3);
            e = exp_roles(raw_in ^ ~pol_cfg);
            check(sig_norm == (raw_in ^ ~pol_cfg), "R1 random", sig_norm, raw_in ^ ~pol_cfg);
            check(bias_en == e[3], bias_always ? "R2 bias" : "R3 bias", bias_en, e[3]);
            check(ob_flag == e[2], "R4 ob", ob_flag, e[2]);
            check(vsr_win == e[1], vsr_en ? "R5 vsr" : "R6 vsr", vsr_win, e[1]);
            check(rr_sw == e[0], "R7 rr", rr_sw, e[0]);
        end

        // R6 directed: qualifier active but reject disabled
        bias_always = 0; cal_only = 1; vsr_en = 0;
        drive(CLAMP, 1); drive(CAL, 1);
        cycles(3);
        check(vsr_win == 1'b0, "R6 disabled", vsr_win, 0);
        vsr_en = 1;
        cycles(1);
        check(vsr_win == 1'b1, "R5 enabled", vsr_win, 1);

        // R8: blank-marker fall, delays 0 and 14, then random
        pol_cfg = 6'($urandom);
        raw_in = ~pol_cfg;
        spix_ref = 0;
        for (int t = 0; t < 6; t++) begin
            int d;
            if (t == 0) begin dly_p1_trail = 0; dly_spix = 0; end
            else if (t == 1) begin dly_p1_trail = 7; dly_spix = 7; end
            else begin dly_p1_trail = 3'($urandom); dly_spix = 3'($urandom); end
            d = dly_p1_trail + dly_spix;
            drive(SBLK, 1);
            cycles(6);
            drive(SBLK, 0);
            pulse_window("R8 delay", 3 + d, 24);
        end

        // R8: pixel-marker rise starts nothing in this mode
        drive(SPIX, 0);
        cycles(4);
        drive(SPIX, 1);
        pulse_window("R8 wrong source", -1, 24);
        drive(SPIX, 0);
        cycles(4);

        // R9: pixel-marker rise with single code
        spix_ref = 1;
        for (int t = 0; t < 5; t++) begin
            dly_p2_lead = (t == 0) ? 3'd0 : (t == 1) ? 3'd7 : 3'($urandom);
            drive(SPIX, 0);
            cycles(6);
            drive(SPIX, 1);
            pulse_window("R9 delay", 3 + int'(dly_p2_lead), 16);
        end

        // R10: retrigger at edge 5 restarts a 7-tick count, one pulse at 14
        dly_p2_lead = 7;
        drive(SPIX, 0);
        cycles(6);
        drive(SPIX, 1);
        begin
            int first = -1;
            int hits = 0;
            for (int c = 1; c <= 30; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (p2_start) begin
                    hits++;
                    if (first < 0) first = c;
                end
                if (c == 2) drive(SPIX, 0);
                if (c == 4) drive(SPIX, 1);
            end
            check(first == 14 && hits == 1, "R10 restart", first * 10 + hits, 141);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule